// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the floating-point status word of a processor core. The word carries five trap enables, five sticky exception flags, a two-bit rounding-mode selector and a flush-to-zero control. When the arithmetic datapath finishes an operation (an add, a conversion, a compare and so on), it reports the raw exception conditions of that operation. The unit folds them into the sticky flags. If any condition raised by that operation has its enable set, the unit asks for an assist trap.

Software replaces the whole status word through a write port and sees the live word on a read port. The unit also decodes the rounding-mode field into a one-hot selector for the datapath. It drives the flush-to-zero control to both the operand-flush and result-flush paths of the datapath, and the datapath flushes tiny results before it rounds them.

Top module: `fpx_status_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `status_word` all zero and `trap_req` low. `rnd_sel` then selects round to nearest even (value 4'b0001), and both flush outputs are low.
- R2: When `sw_wr_en` is high at an edge, `status_word` equals `sw_wr_data` on all 32 bits after that edge.
- R3: A software write and an operation in the same cycle: the written word wins, that operation's exceptions are dropped, and no trap follows.
- R4: When `op_done` is high without a write, each set bit of `exc_raw` is ORed into the flags field. The exc_raw bits are bit4 invalid, bit3 divide-by-zero, bit2 overflow, bit1 underflow and bit0 inexact. Bit k lands in status bit 27+k, so invalid sits at bit 31 and inexact at bit 27. The enables for the same conditions sit at bits 4:0 in the same order.
- R5: If an operation completes with `exc_raw` zero, `status_word` does not change.
- R6: Flags are sticky: no operation ever clears a flag bit; only a software write or reset does.
- R7: `trap_req` is high for exactly the one cycle after an edge where `op_done` was high, no write happened, and `exc_raw` ANDed with enable bits 4:0 was non-zero. It is low otherwise.
- R8: `rnd_sel` decodes status bits 10:9 one-hot: 0 gives bit0 (nearest even), 1 gives bit1 (toward zero), 2 gives bit2 (toward +inf) and 3 gives bit3 (toward -inf).
- R9: Status bit 5 is the flush-to-zero control. `flush_inputs` and `flush_result` both follow it.
- R10: When `op_done` is low, `exc_raw` has no effect on `status_word` or `trap_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe for the status word |
| sw_wr_data | input | 32 | Value to write into the status word |
| op_done | input | 1 | Datapath completed an operation this cycle |
| exc_raw | input | 5 | Raw exceptions of that operation (V,Z,O,U,I from MSB) |
| status_word | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle assist-trap request |
| rnd_sel | output | 4 | One-hot rounding mode for the datapath |
| flush_inputs | output | 1 | Flush denormal operands to zero |
| flush_result | output | 1 | Flush tiny results to zero before rounding |

## Verification
The bench checks that a trap fires only when the enable matches a condition of the current operation. A design that trapped on old sticky flags would fire again after every later operation, and one that compared the flags field with the enables would never fire. It runs a software write and an operation in the same cycle; a design that got the priority wrong would leak the operation's flags into the fresh word or raise a stray trap. It also drives operations that raise no exceptions and exceptions with `op_done` low, where a design that loaded the flags instead of ORing them, or that ignored the strobe, would clear or corrupt earlier flags.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   // rounding modes as encoded in the status word selector field
   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_UP      = 2'd2,
      RM_DOWN    = 2'd3
   } fpx_rmode_e;

   localparam int RM_W     = 2;
   localparam int RM_COUNT = 1 << RM_W;

   // place an exception vector at a base position of a word
   function automatic logic [31:0] place_bits(input logic [31:0] vec, input int base);
      return vec << base;
   endfunction

endpackage

// File: rtl/fpx_exc_map.sv
module fpx_exc_map #(
   parameter int WORD_W   = 32,
   parameter int EXC_N    = 5,
   parameter int ENA_LSB  = 0,
   parameter int FLAG_LSB = 27
) (
   input  logic [EXC_N-1:0]  exc,
   output logic [WORD_W-1:0] ena_vec,
   output logic [WORD_W-1:0] flag_vec
);
   localparam int SHIFT = FLAG_LSB - ENA_LSB;

   // each condition goes to the position of its own enable bit
   for (genvar k = 0; k < WORD_W; k++) begin : g_ena
      if (k >= ENA_LSB && k < ENA_LSB + EXC_N) begin : g_hit
         assign ena_vec[k] = exc[k-ENA_LSB];
      end else begin : g_zero
         assign ena_vec[k] = 1'b0;
      end
   end

   // flags sit a fixed distance above the enables
   assign flag_vec = ena_vec << SHIFT;

endmodule

// File: rtl/fpx_round_decode.sv
module fpx_round_decode
   import fpx_pkg::*;
(
   input  logic [RM_W-1:0]     rm_field,
   input  logic                ftz_bit,
   output logic [RM_COUNT-1:0] rnd_sel,
   output logic                flush_inputs,
   output logic                flush_result
);
   for (genvar m = 0; m < RM_COUNT; m++) begin : g_mode
      assign rnd_sel[m] = (rm_field == RM_W'(m));
   end

   // one control bit governs both flush points
   assign flush_inputs = ftz_bit;
   assign flush_result = ftz_bit;

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg #(
   parameter int WORD_W  = 32,
   parameter int ENA_LSB = 0,
   parameter int EXC_N   = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              op_done,
   input  logic [WORD_W-1:0] ena_vec,
   input  logic [WORD_W-1:0] flag_vec,
   output logic [WORD_W-1:0] status_q,
   output logic              trap_q
);
   localparam logic [WORD_W-1:0] ENA_MASK = ((WORD_W'(1) << EXC_N) - WORD_W'(1)) << ENA_LSB;

   logic hit;
   assign hit = |(ena_vec & status_q & ENA_MASK);

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         trap_q   <= 1'b0;
      end else begin
         trap_q <= op_done && !wr_en && hit;
         if (wr_en) begin
            status_q <= wr_data;
         end else if (op_done) begin
            status_q <= status_q | flag_vec;
         end
      end
   end

endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
   import fpx_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int EXC_N    = 5,
   parameter int ENA_LSB  = 0,
   parameter int FLAG_LSB = 27,
   parameter int FTZ_BIT  = 5,
   parameter int RM_LSB   = 9
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sw_wr_en,
   input  logic [WORD_W-1:0]   sw_wr_data,
   input  logic                op_done,
   input  logic [EXC_N-1:0]    exc_raw,
   output logic [WORD_W-1:0]   status_word,
   output logic                trap_req,
   output logic [RM_COUNT-1:0] rnd_sel,
   output logic                flush_inputs,
   output logic                flush_result
);
   // elaboration-time layout checks
   if (FLAG_LSB + EXC_N > WORD_W) begin : g_bad_flags
      $error("flags field exceeds status word");
   end
   if (FLAG_LSB < ENA_LSB + EXC_N) begin : g_bad_order
      $error("flags field must sit above the enables field");
   end
   if (FTZ_BIT >= ENA_LSB && FTZ_BIT < ENA_LSB + EXC_N) begin : g_bad_ftz
      $error("flush bit overlaps the enables");
   end
   if (RM_LSB + RM_W > FLAG_LSB || RM_LSB < ENA_LSB + EXC_N) begin : g_bad_rm
      $error("rounding field overlaps another field");
   end
   if (FTZ_BIT >= RM_LSB && FTZ_BIT < RM_LSB + RM_W) begin : g_bad_ftz_rm
      $error("flush bit overlaps the rounding field");
   end

   logic [WORD_W-1:0] ena_vec;
   logic [WORD_W-1:0] flag_vec;

   fpx_exc_map #(
      .WORD_W(WORD_W), .EXC_N(EXC_N), .ENA_LSB(ENA_LSB), .FLAG_LSB(FLAG_LSB)
   ) u_map (
      .exc(exc_raw), .ena_vec(ena_vec), .flag_vec(flag_vec)
   );

   fpx_status_reg #(
      .WORD_W(WORD_W), .ENA_LSB(ENA_LSB), .EXC_N(EXC_N)
   ) u_reg (
      .clk(clk), .rst(rst), .wr_en(sw_wr_en), .wr_data(sw_wr_data),
      .op_done(op_done), .ena_vec(ena_vec), .flag_vec(flag_vec),
      .status_q(status_word), .trap_q(trap_req)
   );

   fpx_round_decode u_rdec (
      .rm_field(status_word[RM_LSB +: RM_W]),
      .ftz_bit(status_word[FTZ_BIT]),
      .rnd_sel(rnd_sel),
      .flush_inputs(flush_inputs),
      .flush_result(flush_result)
   );

endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk #(
   parameter int WORD_W   = 32,
   parameter int EXC_N    = 5,
   parameter int ENA_LSB  = 0,
   parameter int FLAG_LSB = 27,
   parameter int FTZ_BIT  = 5,
   parameter int RM_LSB   = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              sw_wr_en,
   input logic [WORD_W-1:0] sw_wr_data,
   input logic              op_done,
   input logic [EXC_N-1:0]  exc_raw,
   input logic [WORD_W-1:0] status_word,
   input logic              trap_req,
   input logic [3:0]        rnd_sel,
   input logic              flush_inputs,
   input logic              flush_result
);
   logic [EXC_N-1:0] flg;
   logic [EXC_N-1:0] ena;
   assign flg = status_word[FLAG_LSB +: EXC_N];
   assign ena = status_word[ENA_LSB +: EXC_N];

   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (status_word == '0 && !trap_req));

   a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sw_wr_en)) |-> status_word == $past(sw_wr_data));

   a_r3_write_no_trap: assert property (@(posedge clk) disable iff (rst)
      $past(sw_wr_en) |-> !trap_req);

   a_r5_quiet_op_stable: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(sw_wr_en) && (!$past(op_done) || $past(exc_raw) == '0))
      |-> $stable(status_word));

   a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(sw_wr_en)) |-> ((flg & $past(flg)) == $past(flg)));

   a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (!$past(rst) && $past(op_done) && ($past(exc_raw) & $past(ena)) != '0));

   a_r8_onehot_mode: assert property (@(posedge clk) disable iff (rst)
      $countones(rnd_sel) == 1);

   a_r9_flush_follow: assert property (@(posedge clk) disable iff (rst)
      (flush_inputs == status_word[FTZ_BIT]) && (flush_result == status_word[FTZ_BIT]));

   a_r10_idle_no_trap: assert property (@(posedge clk) disable iff (rst)
      !$past(op_done) |-> !trap_req);

endmodule

bind fpx_status_unit fpx_status_chk #(
   .WORD_W(WORD_W), .EXC_N(EXC_N), .ENA_LSB(ENA_LSB),
   .FLAG_LSB(FLAG_LSB), .FTZ_BIT(FTZ_BIT), .RM_LSB(RM_LSB)
) u_chk (.*);

// File: tb/tb_fpx_status_unit.sv
module tb_fpx_status_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wr_data = '0;
   logic        op_done = 1'b0;
   logic [4:0]  exc_raw = '0;
   logic [31:0] status_word;
   logic        trap_req;
   logic [3:0]  rnd_sel;
   logic        flush_inputs;
   logic        flush_result;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference state
   logic [31:0] m_status = '0;
   logic        m_trap   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fpx_status_unit dut (
      .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .op_done(op_done), .exc_raw(exc_raw), .status_word(status_word),
      .trap_req(trap_req), .rnd_sel(rnd_sel),
      .flush_inputs(flush_inputs), .flush_result(flush_result)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_rsel(input logic [31:0] st);
      int m;
      m = int'(st[10:9]);
      return 4'(1 << m);
   endfunction

   // one clock: drive at the falling edge, advance the model, compare after the edge
   task automatic step(input logic r, input logic wr, input logic [31:0] wd,
                       input logic op, input logic [4:0] ex, input string tag);
      @(negedge clk);
      rst = r; sw_wr_en = wr; sw_wr_data = wd; op_done = op; exc_raw = ex;
      if (r) begin
         m_status = '0;
         m_trap   = 1'b0;
      end else begin
         m_trap = op && !wr && ((ex & m_status[4:0]) != 5'd0);
         if (wr) m_status = wd;
         else if (op) begin
            for (int k = 0; k < 5; k++)
               if (ex[k]) m_status[27+k] = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      check(tag, "status_word", status_word, m_status);
      check(tag, "trap_req", 32'(trap_req), 32'(m_trap));
      check(tag, "rnd_sel", 32'(rnd_sel), 32'(exp_rsel(m_status)));
      check(tag, "flush", {30'd0, flush_inputs, flush_result}, {30'd0, m_status[5], m_status[5]});
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      // R1: reset state
      step(1, 0, 32'h0, 0, 5'h00, "R1");
      step(1, 1, 32'hFFFF_FFFF, 1, 5'h1F, "R1");
      step(0, 0, 32'h0, 0, 5'h00, "R1");
      // R2: software write, all enables off
      step(0, 1, 32'h0000_0000, 0, 5'h00, "R2");
      // R4: inexact sets bit 27, no enable so no trap
      step(0, 0, 32'h0, 1, 5'b00001, "R4");
      step(0, 0, 32'h0, 1, 5'b10100, "R4");
      // R5: operation with no exceptions
      step(0, 0, 32'h0, 1, 5'b00000, "R5");
      // R10: exceptions without op_done
      step(0, 0, 32'h0, 0, 5'b11111, "R10");
      // R2, R8: write invalid enable, round toward zero
      step(0, 1, 32'h0000_0210, 0, 5'h00, "R2");
      // R6, R7: divide-by-zero not enabled: no trap, flag sticks
      step(0, 0, 32'h0, 1, 5'b01000, "R7");
      step(0, 0, 32'h0, 1, 5'b00010, "R6");
      // R7: invalid enabled: trap pulse, then drops
      step(0, 0, 32'h0, 1, 5'b10000, "R7");
      step(0, 0, 32'h0, 0, 5'b00000, "R7");
      // R7: sticky invalid flag alone must not trap again
      step(0, 0, 32'h0, 1, 5'b00001, "R7");
      // R3: write plus enabled exception in the same cycle
      step(0, 1, 32'h0000_001F, 1, 5'b11111, "R3");
      step(0, 0, 32'h0, 0, 5'b00000, "R3");
      // R8: each rounding mode; R9: flush bit
      for (int m = 0; m < 4; m++)
         step(0, 1, 32'(m) << 9, 0, 5'h00, "R8");
      step(0, 1, 32'h0000_0020, 0, 5'h00, "R9");
      step(0, 1, 32'h0000_0000, 0, 5'h00, "R9");
      // R6: flags survive many operations
      step(0, 1, 32'hF800_0000, 0, 5'h00, "R6");
      step(0, 0, 32'h0, 1, 5'b00000, "R6");
      step(0, 0, 32'h0, 1, 5'b00100, "R6");
      // mixed traffic with occasional reset
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         step((rv[7:0] == 8'd3), (rv[3:0] == 4'd5), $urandom,
              rv[8] | rv[9], 5'(rv[14:10] & rv[19:15]), "R4");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule